// File: doc/BRIEF.md
# PCIe TLP Receive Deframer

This block sits behind a 128-bit receive stream of PCI Express transaction layer packets. Each bus beat carries four dwords (two qwords), framed by a valid strobe, a start-of-packet flag, an end-of-packet flag and a one-bit empty indicator. The indicator says whether the upper qword of the final beat is unused.

From the first beat of each packet the block captures the header and decodes four things: the header size (three or four dwords), whether a payload is present, the payload length, and the qword alignment of the address. It publishes the header with a one-cycle strobe. It then streams the payload out one dword at a time with first and last markers. Alignment pad dwords are dropped on the way.

The payload length is checked against the packet framing. When a packet ends early, runs past its length, or is cut off by a new start-of-packet, the block pulses a framing-error flag. After a framing error it discards beats until the next start-of-packet.

A small dword buffer decouples the four-dword input beats from the one-dword output. The input is held off with a ready signal once two or more dwords are waiting.

The control state machine has three states:
- `ST_IDLE` waits for a packet.
- `ST_PAYLOAD` is inside a packet whose length is not yet covered.
- `ST_DROP` discards the remainder of an overrun packet.

Every accepted start-of-packet beat, whatever the current state, leads to the state that packet's first beat calls for:
- `ST_IDLE` if the beat also ends the packet.
- `ST_DROP` if an overrun is already visible.
- `ST_PAYLOAD` otherwise.

In `ST_PAYLOAD` a beat without start-of-packet follows the same rule. In `ST_IDLE` and `ST_DROP` such a beat leaves the state unchanged.

Top module: `tlp_rx_deframer`

## Requirements
- R1: After reset, out_valid, hdr_valid and frame_err are 0 and in_ready is 1.
- R2: On the start-of-packet beat, dword k sits at in_data[32k+31:32k]. DW0 bit 29 selects a four-dword header and DW0 bit 30 marks a payload. The length is DW0[9:0], where 0 means 1024. The address is unaligned when bit 2 of DW2 (three-dword header) or of DW3 (four-dword header) is 1. One cycle after that beat is accepted, hdr_valid pulses, with hdr_dwords holding the header (dword 3 forced to 0 for a three-dword header) and the decoded fields beside it.
- R3: With a three-dword header and an unaligned address, the first payload dword is in_data[127:96] of the start-of-packet beat.
- R4: With a three-dword header and an aligned address, in_data[127:96] of the start-of-packet beat is a pad, and the payload begins at in_data[31:0] of the next beat.
- R5: With a four-dword header, the payload begins on the second beat. If the address is unaligned, in_data[31:0] of that beat is a pad and is dropped.
- R6: Within a beat, payload dwords leave lowest dword first. When in_empty is 1 on an end-of-packet beat, only in_data[63:0] is used.
- R7: Payload dwords leave in order. out_first marks the packet's first dword and out_last marks its Length-th dword. A packet without payload produces no output.
- R8: While out_valid is 1 and out_ready is 0, out_data, out_first and out_last hold their values.
- R9: in_ready is 0 exactly while two or more dwords wait in the buffer.
- R10: An end-of-packet that arrives before Length dwords have been delivered pulses frame_err one cycle after that beat. The dwords received are still delivered, and none carries out_last.
- R11: Data beyond Length pulses frame_err one cycle after the beat that shows it. Such data is a beat without end-of-packet once the length is covered, or two or more spare dwords on the end-of-packet beat. Later beats are discarded until the next start-of-packet.
- R12: A start-of-packet that arrives while a packet still awaits payload pulses frame_err, and that beat starts a new packet.
- R13: A beat accepted outside a packet, and any start-of-packet or end-of-packet flag seen with in_valid 0, produces no output, no header and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_empty | input | 1 | On the last beat, upper qword unused |
| in_data | input | 128 | Four dwords, dword 0 in the low bits |
| out_valid | output | 1 | Output dword valid |
| out_ready | input | 1 | Consumer takes the dword |
| out_data | output | 32 | Payload dword |
| out_first | output | 1 | First payload dword of a packet |
| out_last | output | 1 | Length-th payload dword of a packet |
| hdr_valid | output | 1 | Header fields updated (one-cycle pulse) |
| hdr_dwords | output | 128 | Captured header dwords |
| hdr_four_dw | output | 1 | Header is four dwords |
| hdr_has_data | output | 1 | Packet carries a payload |
| hdr_unaligned | output | 1 | Address not qword aligned |
| hdr_len | output | 11 | Decoded length in dwords (1..1024) |
| frame_err | output | 1 | Framing error (one-cycle pulse) |

## Verification
The payload path is exercised with every combination of header size and address alignment. Each combination puts the first payload dword in a different lane, so a wrong pad or start position changes the output sequence. Lengths are chosen so the last beat is sometimes full and sometimes half-empty, which separates correct use of the empty flag from reading stale upper lanes. A length field of zero is included to expose a decode that treats it as zero rather than 1024.

The error path uses three stimuli, each producing one error pulse while the delivered prefix stays exact:
- packets cut short by two or more dwords;
- packets extended by four extra dwords;
- a packet left open by a new start-of-packet.

Stalled and randomly paced out_ready, together with stray beats between packets, separate the holding and back-pressure behaviour from the ignore rule.

// File: rtl/tlp_rx_pkg.sv
package tlp_rx_pkg;
    localparam int DW_W      = 32;
    localparam int LANES     = 4;
    localparam int BEAT_W    = DW_W * LANES;
    localparam int LEN_FLD_W = 10;
    localparam int LEN_W     = LEN_FLD_W + 1;
    localparam int CNT_W     = $clog2(LANES + 1);
    localparam int HALF      = LANES / 2;

    // Bit positions that the header decode depends on
    localparam int FMT_4DW_BIT  = 29;
    localparam int FMT_DATA_BIT = 30;
    localparam int ADDR_QW_BIT  = 2;

    typedef logic [DW_W-1:0] dword_t;

    typedef struct packed {
        logic   first;
        logic   last;
        dword_t data;
    } lane_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PAYLOAD,
        ST_DROP
    } rx_state_e;
endpackage

// File: rtl/tlp_hdr_decode.sv
module tlp_hdr_decode
    import tlp_rx_pkg::*;
(
    input  logic                 fmt_four,
    input  logic                 fmt_data,
    input  logic [LEN_FLD_W-1:0] len_field,
    input  logic                 addr_bit_3dw,
    input  logic                 addr_bit_4dw,
    output logic                 four_dw,
    output logic                 has_data,
    output logic                 unaligned,
    output logic [LEN_W-1:0]     len_dw
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(1) << LEN_FLD_W;

    always_comb begin
        four_dw   = fmt_four;
        has_data  = fmt_data;
        unaligned = fmt_four ? addr_bit_4dw : addr_bit_3dw;
        len_dw    = (len_field == '0) ? MAX_LEN : {1'b0, len_field};
    end
endmodule

// File: rtl/tlp_lane_pack.sv
module tlp_lane_pack
    import tlp_rx_pkg::*;
(
    input  logic [BEAT_W-1:0]        beat,
    input  logic [LANES-1:0]         mask,
    input  logic [LEN_W-1:0]         rem,
    input  logic                     at_start,
    output lane_t [LANES-1:0]        lanes,
    output logic  [CNT_W-1:0]        take,
    output logic  [CNT_W-1:0]        avail
);
    always_comb begin
        int k;
        int a;
        k     = 0;
        a     = 0;
        lanes = '0;
        for (int i = 0; i < LANES; i++) begin
            if (mask[i]) begin
                a = a + 1;
                if (LEN_W'(k) < rem) begin
                    lanes[k].data  = beat[i*DW_W +: DW_W];
                    lanes[k].first = at_start && (k == 0);
                    lanes[k].last  = (LEN_W'(k + 1) == rem);
                    k = k + 1;
                end
            end
        end
        take  = CNT_W'(k);
        avail = CNT_W'(a);
    end
endmodule

// File: rtl/tlp_dw_fifo.sv
module tlp_dw_fifo
    import tlp_rx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CNT_W-1:0]           push_n,
    input  lane_t [LANES-1:0]          push_lanes,
    input  logic                       pop,
    output lane_t                      head,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    lane_t         mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (i < int'(push_n)) begin
                mem[wr_ptr + PW'(i)] <= push_lanes[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            wr_ptr  <= wr_ptr + PW'(push_n);
            rd_ptr  <= rd_ptr + PW'(pop);
            count_q <= count_q + CW'(push_n) - CW'(pop);
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (count_q == '0);
    assign count = count_q;
endmodule

// File: rtl/tlp_rx_deframer.sv
module tlp_rx_deframer
    import tlp_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_empty,
    input  logic [BEAT_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DW_W-1:0]   out_data,
    output logic              out_first,
    output logic              out_last,
    output logic              hdr_valid,
    output logic [BEAT_W-1:0] hdr_dwords,
    output logic              hdr_four_dw,
    output logic              hdr_has_data,
    output logic              hdr_unaligned,
    output logic [LEN_W-1:0]  hdr_len,
    output logic              frame_err
);
    localparam int FCW = $clog2(FIFO_DEPTH + 1);

    rx_state_e state_q, state_d, pkt_next;

    logic             dec_four, dec_data, dec_unal;
    logic [LEN_W-1:0] dec_len;

    logic [LEN_W-1:0] rem_q;
    logic             four_q, unal_q, first_pl_q, fresh_q;

    logic [LANES-1:0] valid_mask, pl_mask, lane_mask;
    logic [LEN_W-1:0] cur_rem;
    logic             at_start;
    lane_t [LANES-1:0] packed_lanes;
    logic [CNT_W-1:0] take, avail;
    logic [CNT_W-1:0] push_n;
    logic             beat_acc, beat_live, abandon, err_under, err_over;

    lane_t            head;
    logic             fifo_empty;
    logic [FCW-1:0]   fifo_count;

    // Header field decode on the current beat
    tlp_hdr_decode u_dec (
        .fmt_four     (in_data[FMT_4DW_BIT]),
        .fmt_data     (in_data[FMT_DATA_BIT]),
        .len_field    (in_data[LEN_FLD_W-1:0]),
        .addr_bit_3dw (in_data[2*DW_W + ADDR_QW_BIT]),
        .addr_bit_4dw (in_data[3*DW_W + ADDR_QW_BIT]),
        .four_dw      (dec_four),
        .has_data     (dec_data),
        .unaligned    (dec_unal),
        .len_dw       (dec_len)
    );

    assign beat_acc  = in_valid && in_ready;
    assign beat_live = in_sop || (state_q == ST_PAYLOAD);
    assign abandon   = in_sop && (state_q == ST_PAYLOAD);

    // Lane selection: which dwords of this beat are payload
    always_comb begin
        valid_mask = {{HALF{~(in_eop && in_empty)}}, {HALF{1'b1}}};
        if (in_sop) begin
            pl_mask = '0;
            if (dec_data && !dec_four && dec_unal) begin
                pl_mask[LANES-1] = 1'b1;
            end
        end else begin
            pl_mask = '1;
            if (first_pl_q && four_q && unal_q) begin
                pl_mask[0] = 1'b0;
            end
        end
        lane_mask = pl_mask & valid_mask;
        cur_rem   = in_sop ? (dec_data ? dec_len : '0) : rem_q;
        at_start  = in_sop ? 1'b1 : fresh_q;
    end

    tlp_lane_pack u_pack (
        .beat     (in_data),
        .mask     (lane_mask),
        .rem      (cur_rem),
        .at_start (at_start),
        .lanes    (packed_lanes),
        .take     (take),
        .avail    (avail)
    );

    // Length accounting against the framing
    always_comb begin
        err_under = in_eop && (LEN_W'(avail) < cur_rem);
        if (in_eop) begin
            err_over = (LEN_W'(avail) >= cur_rem + LEN_W'(2));
        end else begin
            err_over = (LEN_W'(avail) >= cur_rem);
        end
        if (in_eop) begin
            pkt_next = ST_IDLE;
        end else if (err_over) begin
            pkt_next = ST_DROP;
        end else begin
            pkt_next = ST_PAYLOAD;
        end
        push_n = (beat_acc && beat_live) ? take : '0;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (beat_acc) begin
            unique case (state_q)
                ST_IDLE, ST_DROP: begin
                    if (in_sop) begin
                        state_d = pkt_next;
                    end
                end
                ST_PAYLOAD: begin
                    state_d = pkt_next;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Packet context, header capture and strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q         <= '0;
            four_q        <= 1'b0;
            unal_q        <= 1'b0;
            first_pl_q    <= 1'b0;
            fresh_q       <= 1'b0;
            hdr_valid     <= 1'b0;
            frame_err     <= 1'b0;
            hdr_dwords    <= '0;
            hdr_four_dw   <= 1'b0;
            hdr_has_data  <= 1'b0;
            hdr_unaligned <= 1'b0;
            hdr_len       <= '0;
        end else begin
            hdr_valid <= beat_acc && in_sop;
            frame_err <= beat_acc && beat_live && (err_under || err_over || abandon);
            if (beat_acc && beat_live) begin
                rem_q      <= cur_rem - LEN_W'(take);
                fresh_q    <= at_start && (take == '0);
                first_pl_q <= in_sop;
            end
            if (beat_acc && in_sop) begin
                four_q        <= dec_four;
                unal_q        <= dec_unal;
                hdr_four_dw   <= dec_four;
                hdr_has_data  <= dec_data;
                hdr_unaligned <= dec_unal;
                hdr_len       <= dec_len;
                hdr_dwords    <= dec_four ? in_data
                                          : {{DW_W{1'b0}}, in_data[3*DW_W-1:0]};
            end
        end
    end

    tlp_dw_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_n     (push_n),
        .push_lanes (packed_lanes),
        .pop        (out_valid && out_ready),
        .head       (head),
        .empty      (fifo_empty),
        .count      (fifo_count)
    );

    assign in_ready  = (fifo_count <= FCW'(1));
    assign out_valid = !fifo_empty;
    assign out_data  = head.data;
    assign out_first = head.first;
    assign out_last  = head.last;
endmodule

// File: rtl/tlp_rx_deframer_chk.sv
module tlp_rx_deframer_chk
    import tlp_rx_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic            in_sop,
    input logic            out_valid,
    input logic            out_ready,
    input logic [DW_W-1:0] out_data,
    input logic            out_first,
    input logic            out_last,
    input logic            hdr_valid,
    input logic            frame_err
);
    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                   && $stable(out_first) && $stable(out_last));

    // R2
    hdr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> $past(in_valid && in_ready && in_sop));

    // R10
    err_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> $past(in_valid && in_ready));

    // R9
    backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid);
endmodule

bind tlp_rx_deframer tlp_rx_deframer_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sop    (in_sop),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_first (out_first),
    .out_last  (out_last),
    .hdr_valid (hdr_valid),
    .frame_err (frame_err)
);

// File: tb/tlp_rx_deframer_tb_top.sv
module tlp_rx_deframer_tb_top;
    import tlp_rx_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_empty = 1'b0;
    logic [127:0]  in_data = '0;
    logic          in_ready;
    logic          out_valid, out_first, out_last;
    logic          out_ready = 1'b1;
    logic [31:0]   out_data;
    logic          hdr_valid, hdr_four_dw, hdr_has_data, hdr_unaligned, frame_err;
    logic [127:0]  hdr_dwords;
    logic [10:0]   hdr_len;

    tlp_rx_deframer dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop),
        .in_empty(in_empty), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_first(out_first), .out_last(out_last),
        .hdr_valid(hdr_valid), .hdr_dwords(hdr_dwords), .hdr_four_dw(hdr_four_dw),
        .hdr_has_data(hdr_has_data), .hdr_unaligned(hdr_unaligned), .hdr_len(hdr_len),
        .frame_err(frame_err)
    );

    typedef struct packed { logic [31:0] d; logic f; logic l; } exp_dw_t;
    typedef struct packed {
        logic four; logic has; logic unal; logic [10:0] len; logic [127:0] dws;
    } exp_hdr_t;

    exp_dw_t  exp_q[$];
    exp_hdr_t hdr_q[$];
    int n_checks = 0, n_fail = 0;
    int err_seen = 0, err_exp = 0;
    int ready_mode = 0;
    int cyc = 0;
    int seq = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Consumer pacing
    always @(negedge clk) begin
        case (ready_mode)
            0: out_ready = 1'b1;
            1: out_ready = (($urandom % 4) != 0);
            default: out_ready = 1'b0;
        endcase
    end

    // Reference comparison, sampled 1 ns before each rising edge
    logic        prev_stall = 1'b0;
    logic [31:0] prev_d;
    logic        prev_f, prev_l;
    always @(negedge clk) begin
        #3;
        if (rst_n) begin
            if (prev_stall) begin
                chk(out_valid && out_data == prev_d && out_first == prev_f && out_last == prev_l,
                    "R8", "held dword", {out_valid, out_first, out_last, out_data},
                    {1'b1, prev_f, prev_l, prev_d});
            end
            prev_stall = out_valid && !out_ready;
            prev_d = out_data; prev_f = out_first; prev_l = out_last;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected dword", {96'd0, out_data}, 0);
                end else begin
                    exp_dw_t e;
                    e = exp_q.pop_front();
                    chk(out_data == e.d && out_first == e.f && out_last == e.l, "R7",
                        "dword/first/last", {out_first, out_last, out_data}, {e.f, e.l, e.d});
                end
            end
            if (hdr_valid) begin
                if (hdr_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected header", hdr_dwords, 0);
                end else begin
                    exp_hdr_t h;
                    h = hdr_q.pop_front();
                    chk(hdr_dwords == h.dws, "R2", "header dwords", hdr_dwords, h.dws);
                    chk({hdr_four_dw, hdr_has_data, hdr_unaligned, hdr_len} ==
                        {h.four, h.has, h.unal, h.len}, "R2", "header fields",
                        {hdr_four_dw, hdr_has_data, hdr_unaligned, hdr_len},
                        {h.four, h.has, h.unal, h.len});
                end
            end
            if (frame_err) err_seen++;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL R7 watchdog expired actual=%0d expected<%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Hold a beat until it is taken; entered and left at a falling edge
    task automatic put_beat(input logic [127:0] d, input bit sop, input bit eop, input bit emp);
        bit ok;
        in_data = d; in_sop = sop; in_eop = eop; in_empty = emp; in_valid = 1'b1;
        do begin
            #3;
            ok = in_ready;
            @(negedge clk);
        end while (!ok);
    endtask

    task automatic idle_bus();
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_empty = 1'b0;
    endtask

    // Build one packet, queue its expected results, and send it
    task automatic send_pkt(input bit four, input bit has, input bit unal, input int lenf,
                            input int short_n, input int extra_n, input bit no_eop);
        logic [31:0] dws[$];
        logic [31:0] pay[$];
        logic [31:0] h0, h1, h2, h3;
        int eff, npay;
        exp_hdr_t eh;
        seq++;
        eff = (lenf == 0) ? 1024 : lenf;
        h0 = '0;
        h0[30] = has; h0[29] = four; h0[9:0] = lenf[9:0]; h0[23:16] = seq[7:0];
        h1 = 32'h5100_0000 | seq;
        h2 = four ? (32'hA000_0000 | seq) : ((32'h0010_0000 * (seq % 16)) | (unal ? 32'h4 : 32'h0));
        h3 = (32'h0200_0000 * (seq % 64)) | (unal ? 32'h4 : 32'h0) | 32'h10;
        dws.push_back(h0); dws.push_back(h1); dws.push_back(h2);
        if (four) dws.push_back(h3);
        eh.four = four; eh.has = has; eh.unal = unal; eh.len = 11'(eff);
        eh.dws = four ? {h3, h2, h1, h0} : {32'h0, h2, h1, h0};
        hdr_q.push_back(eh);
        if (has && ((!four && !unal) || (four && unal))) dws.push_back(32'hDEAD_0000 | seq);
        npay = (has ? eff - short_n : 0) + extra_n;
        for (int k = 0; k < npay; k++) pay.push_back({seq[7:0], 24'(k + 1)});
        if (((dws.size() + pay.size()) % 2) == 1) pay.push_back(32'hBEEF_0000 | seq);
        if (has) begin
            for (int k = 0; k < pay.size() && k < eff; k++) begin
                exp_dw_t e;
                e.d = pay[k]; e.f = (k == 0); e.l = (k + 1 == eff);
                exp_q.push_back(e);
            end
        end
        foreach (pay[k]) dws.push_back(pay[k]);
        for (int b = 0; b < dws.size(); b += 4) begin
            logic [127:0] d;
            int n;
            bit eop;
            d = '0;
            n = (dws.size() - b < 4) ? dws.size() - b : 4;
            for (int k = 0; k < n; k++) d[k*32 +: 32] = dws[b + k];
            eop = (b + 4 >= dws.size()) && !no_eop;
            put_beat(d, b == 0, eop, eop && (n == 2));
        end
        idle_bus();
    endtask

    task automatic drain(input string req);
        int guard;
        guard = 0;
        while ((exp_q.size() != 0 || hdr_q.size() != 0) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, req, "pending payload", exp_q.size(), 0);
        chk(err_seen == err_exp, req, "frame_err pulses", err_seen, err_exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #3;
        // R1: quiet reset state
        chk({out_valid, hdr_valid, frame_err, in_ready} == 4'b0001, "R1", "reset outputs",
            {out_valid, hdr_valid, frame_err, in_ready}, 4'b0001);
        @(negedge clk);

        // R3: three-dword header, unaligned, payload starts in dword 3
        send_pkt(0, 1, 1, 1, 0, 0, 0);  drain("R3");
        send_pkt(0, 1, 1, 6, 0, 0, 0);  drain("R3");
        // R4: three-dword header, aligned, pad in dword 3
        send_pkt(0, 1, 0, 5, 0, 0, 0);  drain("R4");
        send_pkt(0, 1, 0, 2, 0, 0, 0);  drain("R4");
        // R5: four-dword header aligned and unaligned
        send_pkt(1, 1, 0, 4, 0, 0, 0);  drain("R5");
        send_pkt(1, 1, 1, 7, 0, 0, 0);  drain("R5");
        // R6: half-empty last beat
        send_pkt(1, 1, 1, 1, 0, 0, 0);  drain("R6");
        send_pkt(1, 1, 0, 2, 0, 0, 0);  drain("R6");
        // R7: no payload packets (read-like and message-like)
        send_pkt(0, 0, 0, 3, 0, 0, 0);  drain("R7");
        send_pkt(1, 0, 1, 0, 0, 0, 0);  drain("R7");
        // R2: length field 0 means 1024
        send_pkt(1, 1, 0, 0, 0, 0, 0);  drain("R2");

        // R8: randomly paced consumer
        ready_mode = 1;
        for (int p = 0; p < 8; p++) begin
            send_pkt(p % 2, 1, (p / 2) % 2, 3 + p * 3, 0, 0, 0);
        end
        drain("R8");
        ready_mode = 0;

        // R9: stalled consumer forces back-pressure
        ready_mode = 2;
        fork
            send_pkt(1, 1, 0, 12, 0, 0, 0);
            begin
                repeat (12) @(negedge clk);
                #3;
                chk(!in_ready && out_valid, "R9", "in_ready under stall",
                    {in_ready, out_valid}, 2'b01);
                @(negedge clk);
                ready_mode = 0;
            end
        join
        drain("R9");

        // R10: end-of-packet before Length
        err_exp++; send_pkt(0, 1, 0, 9, 2, 0, 0); drain("R10");
        err_exp++; send_pkt(1, 1, 1, 6, 3, 0, 0); drain("R10");
        err_exp++; send_pkt(0, 1, 1, 3, 2, 0, 0); drain("R10");

        // R11: data past Length, rest dropped
        err_exp++; send_pkt(1, 1, 0, 3, 0, 4, 0); drain("R11");
        err_exp++; send_pkt(0, 0, 0, 1, 0, 4, 0); drain("R11");
        err_exp++; send_pkt(0, 1, 1, 5, 0, 4, 0); drain("R11");

        // R12: new start-of-packet while payload still owed
        err_exp++;
        send_pkt(1, 1, 0, 20, 4, 0, 1);
        send_pkt(0, 1, 1, 4, 0, 0, 0);
        drain("R12");

        // R13: stray beats and unqualified flags
        put_beat(128'h1111_2222_3333_4444_5555_6666_7777_8888, 0, 0, 0);
        put_beat(128'h9999_AAAA_BBBB_CCCC_DDDD_EEEE_FFFF_0000, 0, 1, 1);
        in_valid = 1'b0; in_sop = 1'b1; in_eop = 1'b1;
        in_data = {32'h0, 32'h0, 32'h0, 32'h4000_0004};
        @(negedge clk);
        idle_bus();
        drain("R13");
        chk(hdr_q.size() == 0, "R13", "no header from stray input", hdr_q.size(), 0);
        send_pkt(0, 1, 1, 2, 0, 0, 0);  drain("R13");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule